// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

A bus-attached real-time clock. A 32-bit seconds count advances by one on each pulse of a once-per-second tick input (the slow oscillator and its divider live outside the block). A 32-bit alarm compare value, a control/status word and a free 32-bit scratch word complete the register set. Software reads registers at any time, combinationally, through a simple address/data port. The seconds value may step between two reads, so software reads it twice and accepts the value when both reads agree.

Writes model a slow backing domain. A write is taken only while the ready bit in the control word is 1. The write then takes a fixed number of clock cycles to land, and during that time ready is 0 and the target still shows its old value. Two sticky event flags exist: a once-per-second update flag and an alarm flag. Each flag has its own interrupt enable, and both feed one interrupt line. Software clears a flag by writing 0 to it. Writing 1 keeps the flag, so read-modify-write sequences do not lose events.

Top module: `sec_rtc`

## Requirements
- R1: After reset the control word reads 0x00000080 (ready set, all other bits 0), the seconds, alarm and scratch registers read 0, and `irq` is 0.
- R2: A write presented while ready (control bit 7) is 1 is captured at that clock edge. Ready then reads 0 for WR_LAT cycles, the target keeps its old value during that window, and the new value appears in the same cycle that ready returns to 1. A write presented while ready is 0 is dropped.
- R3: While count enable (control bit 0) is 1, each tick pulse adds one to the seconds register, and 0xFFFFFFFF wraps to 0. While the bit is 0, ticks leave the count unchanged.
- R4: A write to the seconds register (offset 0x04) loads the written value. If a tick falls on the same edge as that load, the load wins and the tick is lost.
- R5: The update flag (control bit 6) becomes 1 on every edge where the count advances.
- R6: The alarm flag (control bit 4) becomes 1 on the tick that moves the count onto the alarm value (offset 0x08), but only while alarm enable (control bit 2) is 1. With alarm enable at 0 it stays 0.
- R7: A control write (offset 0x00) with 0 in bit 6 or bit 4 clears that flag, and 1 leaves it as it was. When a flag's set event falls on the same edge as a clearing write, the flag ends up 1.
- R8: `irq` is 1 exactly when (bit 6 and update interrupt enable, bit 5) or (bit 4 and alarm interrupt enable, bit 3). Control readback is {24'b0, ready, bit6, bit5, bit4, bit3, bit2, 1'b0, bit0}.
- R9: The scratch register (offset 0x34) returns the last value written to it. Offset 0x0C and all unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second from the slow time base |
| bus_addr | input | 6 | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, taken only while ready is 1 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Combined level interrupt |

## Verification
A wrong write-window counter shows up first through control bit 7. Its length is measured exactly: ready is sampled 0 on each of the WR_LAT cycles after a write and 1 on the next. A write dropped or committed early shows up through the target register in the same cycle. A counter or flag fault shows up one edge after the tick that caused it, as a wrong seconds value or a wrong flag bit on readback, and `irq` follows the flags with no added delay. Tick-against-write collisions are placed on the exact commit edge, so the load-wins rule for the seconds register and the set-wins rule for the flags are each checked in the cycle where they apply.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int DW = 32;
    localparam int AW = 6;

    // register offsets (byte addresses)
    localparam logic [AW-1:0] OFS_CTRL = 6'h00;
    localparam logic [AW-1:0] OFS_SEC  = 6'h04;
    localparam logic [AW-1:0] OFS_ALM  = 6'h08;
    localparam logic [AW-1:0] OFS_REGU = 6'h0C;
    localparam logic [AW-1:0] OFS_SCR  = 6'h34;

    // control word bit positions
    localparam int B_RDY  = 7;
    localparam int B_HZF  = 6;
    localparam int B_HZIE = 5;
    localparam int B_ALF  = 4;
    localparam int B_ALIE = 3;
    localparam int B_ALEN = 2;
    localparam int B_CEN  = 0;

    typedef struct packed {
        logic hz_ie;
        logic al_ie;
        logic al_en;
        logic cnt_en;
    } ctl_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wreq_t;

    function automatic ctl_t ctl_from_word(input logic [DW-1:0] w);
        ctl_t c;
        c.hz_ie  = w[B_HZIE];
        c.al_ie  = w[B_ALIE];
        c.al_en  = w[B_ALEN];
        c.cnt_en = w[B_CEN];
        return c;
    endfunction

    function automatic logic [DW-1:0] ctl_word(input ctl_t c, input logic rdy,
                                               input logic hzf, input logic alf);
        logic [DW-1:0] w;
        w         = '0;
        w[B_RDY]  = rdy;
        w[B_HZF]  = hzf;
        w[B_HZIE] = c.hz_ie;
        w[B_ALF]  = alf;
        w[B_ALIE] = c.al_ie;
        w[B_ALEN] = c.al_en;
        w[B_CEN]  = c.cnt_en;
        return w;
    endfunction

endpackage

// File: rtl/sec_rtc_wgate.sv
module sec_rtc_wgate
    import sec_rtc_pkg::*;
#(
    parameter int WR_LAT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  wreq_t req_in,
    output logic  ready,
    output logic  commit,
    output wreq_t held
);
    localparam int CW = $clog2(WR_LAT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else if (req_valid && cnt == '0) begin
            cnt  <= CW'(WR_LAT);
            held <= req_in;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign ready  = (cnt == '0);
    assign commit = (cnt == CW'(1));

endmodule

// File: rtl/sec_rtc_count.sv
module sec_rtc_count #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] count,
    output logic          step
);
    assign step = tick & en & ~load;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (step)
            count <= count + DW'(1);
    end

endmodule

// File: rtl/sec_rtc_flags.sv
module sec_rtc_flags (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic alarm_hit,
    input  logic clr_req,
    input  logic keep_hz,
    input  logic keep_al,
    output logic hz_flag,
    output logic al_flag
);
    logic drop_hz, drop_al;

    assign drop_hz = clr_req & ~keep_hz;
    assign drop_al = clr_req & ~keep_al;

    // a set event on the same edge as a clear wins
    always_ff @(posedge clk) begin
        if (rst) begin
            hz_flag <= 1'b0;
            al_flag <= 1'b0;
        end else begin
            hz_flag <= (hz_flag & ~drop_hz) | step;
            al_flag <= (al_flag & ~drop_al) | alarm_hit;
        end
    end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int WR_LAT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    wreq_t         req, held;
    logic          ready, commit;
    logic          sel_ctrl, sec_load, sel_alm, sel_scr;
    ctl_t          ctl;
    logic          al_en;
    logic [DW-1:0] alarm, scratch, sec, sec_next;
    logic          step, alarm_hit, hz_flag, al_flag;

    assign req.addr = bus_addr;
    assign req.data = bus_wdata;

    sec_rtc_wgate #(.WR_LAT(WR_LAT)) u_wgate (
        .clk       (clk),
        .rst       (rst),
        .req_valid (bus_wr),
        .req_in    (req),
        .ready     (ready),
        .commit    (commit),
        .held      (held)
    );

    assign sel_ctrl = commit && held.addr == OFS_CTRL;
    assign sec_load = commit && held.addr == OFS_SEC;
    assign sel_alm  = commit && held.addr == OFS_ALM;
    assign sel_scr  = commit && held.addr == OFS_SCR;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            alarm   <= '0;
            scratch <= '0;
        end else begin
            if (sel_ctrl) ctl     <= ctl_from_word(held.data);
            if (sel_alm)  alarm   <= held.data;
            if (sel_scr)  scratch <= held.data;
        end
    end

    assign al_en = ctl.al_en;

    sec_rtc_count #(.DW(DW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .en       (ctl.cnt_en),
        .load     (sec_load),
        .load_val (held.data),
        .count    (sec),
        .step     (step)
    );

    assign sec_next  = sec + DW'(1);
    assign alarm_hit = step & al_en & (sec_next == alarm);

    sec_rtc_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .alarm_hit (alarm_hit),
        .clr_req   (sel_ctrl),
        .keep_hz   (held.data[B_HZF]),
        .keep_al   (held.data[B_ALF]),
        .hz_flag   (hz_flag),
        .al_flag   (al_flag)
    );

    assign irq = (hz_flag & ctl.hz_ie) | (al_flag & ctl.al_ie);

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = ctl_word(ctl, ready, hz_flag, al_flag);
            OFS_SEC:  bus_rdata = sec;
            OFS_ALM:  bus_rdata = alarm;
            OFS_SCR:  bus_rdata = scratch;
            OFS_REGU: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic        ready,
    input logic        commit,
    input logic [31:0] sec,
    input logic        step,
    input logic        sec_load,
    input logic        hz_flag,
    input logic        al_flag,
    input logic        al_en,
    input logic        irq
);
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ready) |=> !ready);

    assert_commit_only_when_busy_R2: assert property (@(posedge clk) disable iff (rst)
        commit |-> !ready);

    assert_step_adds_one_R3: assert property (@(posedge clk) disable iff (rst)
        step |=> sec == $past(sec) + 32'd1);

    assert_count_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!step && !sec_load) |=> $stable(sec));

    assert_hz_rise_needs_step_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(hz_flag) |-> $past(step));

    assert_alarm_rise_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(al_flag) |-> $past(step && al_en));

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        !(hz_flag || al_flag) |-> !irq);

endmodule

bind sec_rtc sec_rtc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .ready    (ready),
    .commit   (commit),
    .sec      (sec),
    .step     (step),
    .sec_load (sec_load),
    .hz_flag  (hz_flag),
    .al_flag  (al_flag),
    .al_en    (al_en),
    .irq      (irq)
);

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;
    import sec_rtc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WR_LAT     = 4;
    localparam int NV         = 7;

    // table: write address, write data, expected readback at the same address
    localparam logic [5:0]  TV_ADDR [NV] = '{6'h34, 6'h34, 6'h08, 6'h04, 6'h00, 6'h0C, 6'h00};
    localparam logic [31:0] TV_DATA [NV] = '{32'h1234_5678, 32'hA5A5_0F0F, 32'hFFFF_FFFF,
                                             32'h0000_0100, 32'h0000_006E, 32'hDEAD_BEEF,
                                             32'h0000_0000};
    localparam logic [31:0] TV_EXP  [NV] = '{32'h1234_5678, 32'hA5A5_0F0F, 32'hFFFF_FFFF,
                                             32'h0000_0100, 32'h0000_00AC, 32'h0000_0000,
                                             32'h0000_0080};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sec_rtc #(.WR_LAT(WR_LAT)) u_sec_rtc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_rdy();
        logic [31:0] v;
        do rd(OFS_CTRL, v); while (!v[B_RDY]);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wait_rdy();
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_done(input logic [5:0] a, input logic [31:0] d);
        wr(a, d);
        wait_rdy();
    endtask

    // write whose commit edge coincides with a tick pulse
    task automatic wr_tick(input logic [5:0] a, input logic [31:0] d);
        wr(a, d);
        repeat (WR_LAT - 1) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        wait_rdy();
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic expect_irq(input string tag, input logic exp);
        @(negedge clk);
        #1;
        chk(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg("R1 ctrl after reset", OFS_CTRL, 32'h0000_0080);
        expect_reg("R1 seconds after reset", OFS_SEC, 32'h0);
        expect_reg("R1 alarm after reset", OFS_ALM, 32'h0);
        expect_reg("R1 scratch after reset", OFS_SCR, 32'h0);
        expect_irq("R1 irq after reset", 1'b0);

        // table walk: R2 R4 R8 R9 write/readback
        for (int i = 0; i < NV; i++) begin
            wr_done(TV_ADDR[i], TV_DATA[i]);
            rd(TV_ADDR[i], v);
            chk($sformatf("R2/R8/R9 vector %0d", i), v, TV_EXP[i]);
        end

        // R2 write window: busy length, old value held, busy write dropped
        wr(OFS_SCR, 32'h1111_2222);
        bus_addr = OFS_CTRL;
        #1;
        chk("R2 ready low after accept", {31'b0, bus_rdata[B_RDY]}, 32'h0);
        bus_addr  = OFS_SCR;
        bus_wdata = 32'h3333_4444;
        bus_wr    = 1'b1;
        #1;
        chk("R2 old value during window", bus_rdata, 32'hA5A5_0F0F);
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        bus_addr = OFS_CTRL;
        #1;
        chk("R2 ready still low on last window cycle", {31'b0, bus_rdata[B_RDY]}, 32'h0);
        @(negedge clk);
        #1;
        chk("R2 ready back after WR_LAT cycles", {31'b0, bus_rdata[B_RDY]}, 32'h1);
        bus_addr = OFS_SCR;
        #1;
        chk("R2 new value with ready", bus_rdata, 32'h1111_2222);
        repeat (2 * WR_LAT) @(negedge clk);
        expect_reg("R2 busy write dropped", OFS_SCR, 32'h1111_2222);

        // R3 counting, R5 update flag, R8 irq, R7 clear
        wr_done(OFS_SEC, 32'd5);
        wr_done(OFS_CTRL, 32'h51);
        repeat (3) pulse_tick();
        expect_reg("R3 count after three ticks", OFS_SEC, 32'd8);
        expect_reg("R5 update flag set", OFS_CTRL, 32'hC1);
        expect_irq("R8 irq off with enable clear", 1'b0);
        wr_done(OFS_CTRL, 32'h71);
        expect_irq("R8 irq from update flag", 1'b1);
        wr_done(OFS_CTRL, 32'h21);
        expect_reg("R7 write 0 clears update flag", OFS_CTRL, 32'hA1);
        expect_irq("R8 irq drops with flag", 1'b0);

        // R3 disabled counter ignores tick
        wr_done(OFS_CTRL, 32'h50);
        pulse_tick();
        expect_reg("R3 disabled count holds", OFS_SEC, 32'd8);
        expect_reg("R5 no flag without step", OFS_CTRL, 32'h80);

        // R3 wrap
        wr_done(OFS_SEC, 32'hFFFF_FFFF);
        wr_done(OFS_CTRL, 32'h51);
        pulse_tick();
        expect_reg("R3 wrap to zero", OFS_SEC, 32'h0);

        // R6 alarm
        wr_done(OFS_ALM, 32'd10);
        wr_done(OFS_SEC, 32'd8);
        wr_done(OFS_CTRL, 32'h5D);
        pulse_tick();
        expect_reg("R6 no alarm before match", OFS_CTRL, 32'hCD);
        expect_irq("R8 irq low before alarm", 1'b0);
        pulse_tick();
        expect_reg("R6 alarm flag on match", OFS_CTRL, 32'hDD);
        expect_irq("R8 irq from alarm flag", 1'b1);
        wr_done(OFS_CTRL, 32'h4D);
        expect_reg("R7 alarm cleared update kept", OFS_CTRL, 32'hCD);
        expect_irq("R8 irq low after alarm clear", 1'b0);

        // R6 alarm disabled
        wr_done(OFS_SEC, 32'd8);
        wr_done(OFS_CTRL, 32'h59);
        repeat (2) pulse_tick();
        expect_reg("R3 count reaches alarm value", OFS_SEC, 32'd10);
        expect_reg("R6 no alarm when disabled", OFS_CTRL, 32'hC9);

        // R4 load beats simultaneous tick
        wr_tick(OFS_SEC, 32'h500);
        expect_reg("R4 load wins over tick", OFS_SEC, 32'h500);

        // R7 set beats simultaneous clear
        wr_done(OFS_CTRL, 32'h09);
        expect_reg("R7 both flags cleared", OFS_CTRL, 32'h89);
        wr_tick(OFS_CTRL, 32'h01);
        expect_reg("R7 set wins over clear", OFS_CTRL, 32'hC1);
        expect_reg("R3 tick on ctrl commit counted", OFS_SEC, 32'h501);

        // R9 unmapped offset
        expect_reg("R9 unmapped reads zero", 6'h10, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule